// File: doc/BRIEF.md
# Card command sequencer

This block is the command half of a memory-card host controller. Software programs a 6-bit command index, a 32-bit argument (as two 16-bit halves), a block length, a block count and a command control word through a small register port. A command goes out to the card once two things have happened, in either order: the control word has been written and the card clock has been started. The command is then presented to a card model as a one-cycle strobe. The block gathers the card's response bytes, packs them into a nine-entry 16-bit response store and decides whether enough bytes arrived for the selected response type.

After a good response, a command with data enabled opens a data phase. In that phase the block reports the transfer direction and a byte budget equal to block count times block length; moving the data itself belongs to a neighbouring block. Every issued command ends with a one-cycle end-of-command pulse, whether it completed or timed out.

Register indices on `reg_addr`: 0 clock control (write only, reads 0), 1 status, 2 control word, 3 command index, 4 argument bits 31:16, 5 argument bits 15:0, 6 block length, 7 block count, 8 response store (each read advances it).

Top module: `card_cmd_seq`

## Requirements
- R1: The control word (index 2) keeps only the bits under mask 0x3DFF and reads back exactly what was kept. Its fields are: bits 1:0 response type, bit 2 data enable, bit 3 direction (1 = write to the card), bit 7 DMA enable, bit 10 stop-transfer.
- R2: When the control word is written with bit 10 clear while the clock is running, `cmd_valid` is high for exactly one cycle, in the cycle after the write. `cmd_index` and `cmd_arg` carry the programmed values in that cycle.
- R3: Writing the clock control register (index 0) with bit 1 set sets status bit 8. If a control-word write is still pending and its bit 10 is clear, the command is issued one cycle later. A control word written with bit 10 set is never issued.
- R4: Writing index 0 with bit 0 set clears status bit 8 and `clk_on`, and ends any command or data phase in progress. If bits 0 and 1 are both set in one write, stop wins and nothing is issued.
- R5: Response type 0 completes in the cycle after the strobe without waiting for the card, and sets status bit 13.
- R6: Types 1 and 3 need at least 4 response bytes and type 2 at least 16, counted up to the byte marked last. With fewer bytes, status bit 1 is set instead of bit 13.
- R7: If no last byte arrives within RSP_WAIT cycles after the strobe, the command ends with status bit 1 set.
- R8: Response byte 2k goes to bits 7:0 of entry k and byte 2k+1 to bits 15:8. Bytes beyond 18 are dropped. The store is zeroed when a command is issued.
- R9: Reads of index 8 return entries 0 to 8 in turn and 0 after that. A successful completion rewinds the read position to entry 0.
- R10: `end_cmd` is high for one cycle after each issued command that is not aborted, whether it completed or timed out.
- R11: After a successful completion with data enabled, `xfer_active` rises one cycle after `end_cmd`. In that phase `xfer_bytes` equals block count times block length and `xfer_write` equals control bit 3. There is no data phase after a timeout.
- R12: The command index keeps 6 bits and reads back with bit 6 set. The argument halves read back separately. Block length keeps 12 bits and block count 16 bits.
- R13: Issuing a command, or writing the control word with bit 10 clear, clears status bits 1 and 13 and leaves bit 8 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the response store at index 8) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cmd_valid | output | 1 | One-cycle command strobe to the card |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | A response byte is present |
| rsp_last | input | 1 | The present byte is the final one |
| rsp_byte | input | 8 | Response byte |
| end_cmd | output | 1 | End-of-command pulse |
| xfer_active | output | 1 | Data phase open |
| xfer_write | output | 1 | Data phase direction, 1 = write to the card |
| xfer_bytes | output | 28 | Byte budget of the data phase |
| clk_on | output | 1 | Card clock enabled |
| status | output | 16 | Bit 1 timeout, bit 8 clock on, bit 13 response done |

## Verification
The assertions check on every cycle that the command strobe and the end pulse last one cycle each, and that a clock stop closes everything on the next edge. They also check that a control word with stop-transfer set never yields a strobe, that each ending carries exactly one of the timeout and done bits, and that a data phase only opens right after an ending. What only the bench's scenarios can show is the arithmetic and the ordering. That covers the byte count against each response type, the packing of bytes into the store and the nine-read limit with rewind, the wait window, and the two orders in which the clock and the control word can meet. It also covers the byte budget of the data phase.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_DATA,
        SQ_DONE
    } sq_state_e;

    // register indices
    localparam logic [3:0] RA_CLOCK  = 4'd0;
    localparam logic [3:0] RA_STATUS = 4'd1;
    localparam logic [3:0] RA_CTRL   = 4'd2;
    localparam logic [3:0] RA_INDEX  = 4'd3;
    localparam logic [3:0] RA_ARG_HI = 4'd4;
    localparam logic [3:0] RA_ARG_LO = 4'd5;
    localparam logic [3:0] RA_BLKLEN = 4'd6;
    localparam logic [3:0] RA_BLKCNT = 4'd7;
    localparam logic [3:0] RA_RESP   = 4'd8;

    localparam logic [13:0] CTRL_KEEP = 14'h3DFF;

    // control word fields
    localparam int CB_DATA_EN = 2;
    localparam int CB_WRITE   = 3;
    localparam int CB_STOP    = 10;

    // status bits
    localparam int SB_TOUT = 1;
    localparam int SB_CLK  = 8;
    localparam int SB_DONE = 13;

    // clock control bits
    localparam int CK_HALT = 0;
    localparam int CK_GO   = 1;

endpackage

// File: rtl/card_seq_resp_store.sv
module card_seq_resp_store #(
    parameter int DEPTH = 9,
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic             rewind,
    input  logic             pop,
    output logic [15:0]      rd_word
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][15:0] ent;
        logic [PTR_W-1:0]       ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < DEPTH; k++) begin
            if (clr) begin
                st_d.ent[k] = '0;
            end else if (wr_en && wr_pos == POS_W'(2 * k)) begin
                st_d.ent[k][7:0] = wr_byte;
            end else if (wr_en && wr_pos == POS_W'(2 * k + 1)) begin
                st_d.ent[k][15:8] = wr_byte;
            end
        end
        if (rewind) begin
            st_d.ptr = '0;
        end else if (pop && st_q.ptr < PTR_W'(DEPTH)) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (st_q.ptr == PTR_W'(k)) rd_word = st_q.ent[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
    import card_seq_pkg::*;
#(
    parameter int RSP_WAIT = 32,
    parameter int CNT_W    = 5,
    parameter int XFER_W   = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [1:0]        rsp_type,
    input  logic              data_en,
    input  logic [XFER_W-1:0] xfer_len,
    input  logic              rsp_valid,
    input  logic              rsp_last,
    output logic              cmd_strobe,
    output logic              capture,
    output logic [CNT_W-1:0]  cap_pos,
    output logic              fin_ok,
    output logic              fin_tout,
    output logic              end_pulse,
    output logic              xfer_on,
    output logic [XFER_W-1:0] xfer_bytes
);
    localparam int TMR_W = $clog2(RSP_WAIT + 1);

    typedef struct packed {
        sq_state_e         st;
        logic [TMR_W-1:0]  tmr;
        logic [CNT_W-1:0]  cnt;
        logic              ok;
        logic [XFER_W-1:0] bytes;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [CNT_W:0] need_n;
    logic [CNT_W:0] got_n;

    always_comb begin
        unique case (rsp_type)
            2'd0:    need_n = '0;
            2'd2:    need_n = (CNT_W + 1)'(16);
            default: need_n = (CNT_W + 1)'(4);
        endcase
        got_n = (CNT_W + 1)'(f_q.cnt) + (CNT_W + 1)'(1);
    end

    always_comb begin
        f_d      = f_q;
        fin_ok   = 1'b0;
        fin_tout = 1'b0;
        unique case (f_q.st)
            SQ_ISSUE: begin
                f_d.tmr = '0;
                f_d.cnt = '0;
                if (rsp_type == 2'd0) begin
                    fin_ok   = 1'b1;
                    f_d.st   = SQ_DONE;
                end else begin
                    f_d.st   = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (rsp_valid && f_q.cnt != '1) f_d.cnt = f_q.cnt + 1'b1;
                if (rsp_valid && rsp_last) begin
                    fin_ok   = (got_n >= need_n);
                    fin_tout = (got_n < need_n);
                    f_d.st   = SQ_DONE;
                end else if (f_q.tmr == TMR_W'(RSP_WAIT - 1)) begin
                    fin_tout = 1'b1;
                    f_d.st   = SQ_DONE;
                end else begin
                    f_d.tmr  = f_q.tmr + 1'b1;
                end
            end
            SQ_DONE: begin
                if (f_q.ok && data_en) begin
                    f_d.st    = SQ_DATA;
                    f_d.bytes = xfer_len;
                end else begin
                    f_d.st    = SQ_IDLE;
                end
            end
            default: ;
        endcase
        if (fin_ok || fin_tout) f_d.ok = fin_ok;
        if (start || abort) begin
            fin_ok   = 1'b0;
            fin_tout = 1'b0;
            f_d.st   = start ? SQ_ISSUE : SQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.st    <= SQ_IDLE;
        end else begin
            f_q       <= f_d;
        end
    end

    assign cmd_strobe = (f_q.st == SQ_ISSUE);
    assign capture    = (f_q.st == SQ_WAIT) && rsp_valid;
    assign cap_pos    = f_q.cnt;
    assign end_pulse  = (f_q.st == SQ_DONE);
    assign xfer_on    = (f_q.st == SQ_DATA);
    assign xfer_bytes = f_q.bytes;

endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
    import card_seq_pkg::*;
#(
    parameter int RSP_WAIT   = 32,
    parameter int RESP_DEPTH = 9,
    parameter int BLEN_W     = 12,
    parameter int BCNT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [3:0]               reg_addr,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              reg_rdata,
    output logic                     cmd_valid,
    output logic [5:0]               cmd_index,
    output logic [31:0]              cmd_arg,
    input  logic                     rsp_valid,
    input  logic                     rsp_last,
    input  logic [7:0]               rsp_byte,
    output logic                     end_cmd,
    output logic                     xfer_active,
    output logic                     xfer_write,
    output logic [BLEN_W+BCNT_W-1:0] xfer_bytes,
    output logic                     clk_on,
    output logic [15:0]              status
);
    localparam int XFER_W = BLEN_W + BCNT_W;
    localparam int CNT_W  = $clog2(2 * RESP_DEPTH + 2);

    typedef struct packed {
        logic [13:0]       ctrl;
        logic [5:0]        idx;
        logic [31:0]       arg;
        logic [BLEN_W-1:0] blen;
        logic [BCNT_W-1:0] bcnt;
        logic              clk_on;
        logic              pend;
        logic              s_tout;
        logic              s_done;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_clock, wr_ctrl, clk_go, clk_halt, issue, abort, clr_stat;
    logic fin_ok, fin_tout, capture;
    logic [CNT_W-1:0] cap_pos;
    logic [15:0] resp_word;

    assign wr_clock = reg_wr && reg_addr == RA_CLOCK;
    assign wr_ctrl  = reg_wr && reg_addr == RA_CTRL;
    assign clk_go   = wr_clock && reg_wdata[CK_GO];
    assign clk_halt = wr_clock && reg_wdata[CK_HALT];
    assign issue    = (wr_ctrl && !reg_wdata[CB_STOP] && r_q.clk_on)
                   || (clk_go && !clk_halt && r_q.pend && !r_q.ctrl[CB_STOP]);
    assign abort    = wr_ctrl || clk_halt;
    assign clr_stat = (wr_ctrl && !reg_wdata[CB_STOP]) || issue;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl = reg_wdata[13:0] & CTRL_KEEP;
            r_d.pend = 1'b1;
        end
        if (clk_go)   r_d.clk_on = 1'b1;
        if (clk_halt) r_d.clk_on = 1'b0;
        if (issue)    r_d.pend   = 1'b0;
        if (clr_stat) begin
            r_d.s_tout = 1'b0;
            r_d.s_done = 1'b0;
        end
        if (fin_ok)   r_d.s_done = 1'b1;
        if (fin_tout) r_d.s_tout = 1'b1;
        if (reg_wr) begin
            unique case (reg_addr)
                RA_INDEX:  r_d.idx        = reg_wdata[5:0];
                RA_ARG_HI: r_d.arg[31:16] = reg_wdata;
                RA_ARG_LO: r_d.arg[15:0]  = reg_wdata;
                RA_BLKLEN: r_d.blen       = reg_wdata[BLEN_W-1:0];
                RA_BLKCNT: r_d.bcnt       = reg_wdata[BCNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        status          = '0;
        status[SB_TOUT] = r_q.s_tout;
        status[SB_CLK]  = r_q.clk_on;
        status[SB_DONE] = r_q.s_done;
    end

    always_comb begin
        unique case (reg_addr)
            RA_STATUS: reg_rdata = status;
            RA_CTRL:   reg_rdata = 16'(r_q.ctrl);
            RA_INDEX:  reg_rdata = {9'd0, 1'b1, r_q.idx};
            RA_ARG_HI: reg_rdata = r_q.arg[31:16];
            RA_ARG_LO: reg_rdata = r_q.arg[15:0];
            RA_BLKLEN: reg_rdata = 16'(r_q.blen);
            RA_BLKCNT: reg_rdata = 16'(r_q.bcnt);
            RA_RESP:   reg_rdata = resp_word;
            default:   reg_rdata = '0;
        endcase
    end

    card_seq_fsm #(
        .RSP_WAIT (RSP_WAIT),
        .CNT_W    (CNT_W),
        .XFER_W   (XFER_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (issue),
        .abort      (abort),
        .rsp_type   (r_q.ctrl[1:0]),
        .data_en    (r_q.ctrl[CB_DATA_EN]),
        .xfer_len   (XFER_W'(r_q.blen) * XFER_W'(r_q.bcnt)),
        .rsp_valid  (rsp_valid),
        .rsp_last   (rsp_last),
        .cmd_strobe (cmd_valid),
        .capture    (capture),
        .cap_pos    (cap_pos),
        .fin_ok     (fin_ok),
        .fin_tout   (fin_tout),
        .end_pulse  (end_cmd),
        .xfer_on    (xfer_active),
        .xfer_bytes (xfer_bytes)
    );

    card_seq_resp_store #(
        .DEPTH (RESP_DEPTH),
        .POS_W (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (issue),
        .wr_en   (capture),
        .wr_pos  (cap_pos),
        .wr_byte (rsp_byte),
        .rewind  (fin_ok),
        .pop     (reg_rd && reg_addr == RA_RESP),
        .rd_word (resp_word)
    );

    assign cmd_index  = r_q.idx;
    assign cmd_arg    = r_q.arg;
    assign clk_on     = r_q.clk_on;
    assign xfer_write = r_q.ctrl[CB_WRITE];

endmodule

// File: rtl/card_cmd_seq_chk.sv
module card_cmd_seq_chk
    import card_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        cmd_valid,
    input logic        end_cmd,
    input logic        xfer_active,
    input logic        clk_on,
    input logic [15:0] status
);
    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(reg_wr && reg_addr == RA_CTRL)) |=> !cmd_valid);

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |=> !end_cmd);

    // R4
    clk_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CLOCK && reg_wdata[CK_HALT])
            |=> (!clk_on && !xfer_active && !cmd_valid && !status[SB_CLK]));

    // R3
    stop_tran_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CTRL && reg_wdata[CB_STOP]) |=> !cmd_valid);

    // R6
    end_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |-> (status[SB_TOUT] != status[SB_DONE]));

    // R11
    xfer_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> $past(end_cmd));

endmodule

bind card_cmd_seq card_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cmd_valid   (cmd_valid),
    .end_cmd     (end_cmd),
    .xfer_active (xfer_active),
    .clk_on      (clk_on),
    .status      (status)
);

// File: tb/card_cmd_seq_bench.sv
`timescale 1ns/1ps
module card_cmd_seq_bench;
    localparam int RSP_WAIT = 32;
    localparam int DEPTH    = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        cmd_valid;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        rsp_valid = 1'b0, rsp_last = 1'b0;
    logic [7:0]  rsp_byte = 8'd0;
    logic        end_cmd, xfer_active, xfer_write, clk_on;
    logic [27:0] xfer_bytes;
    logic [15:0] status;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    card_cmd_seq #(.RSP_WAIT(RSP_WAIT)) u_card_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_byte(rsp_byte),
        .end_cmd(end_cmd), .xfer_active(xfer_active), .xfer_write(xfer_write),
        .xfer_bytes(xfer_bytes), .clk_on(clk_on), .status(status)
    );

    // card model: answers each strobe with card_plan bytes
    int card_plan = 0, card_left = 0, card_i = 0;
    logic [7:0] card_seed = 8'h10;
    always @(posedge clk) begin
        if (rsp_valid) begin card_left--; card_i++; end
        if (cmd_valid) begin card_left = card_plan; card_i = 0; end
        #1;
        rsp_valid = card_left > 0;
        rsp_last  = card_left == 1;
        rsp_byte  = card_seed + 8'(card_i * 13);
    end

    // behavioural reference: phase 0 idle, 1 strobe, 2 waiting, 3 data, 4 ended
    int          m_ph = 0, m_wait = 0, m_got = 0, m_ptr = 0;
    bit          m_clk = 0, m_pend = 0, m_tout = 0, m_done = 0, m_good = 0;
    logic [15:0] m_ctrl = 0;
    logic [5:0]  m_idx = 0;
    logic [31:0] m_arg = 0;
    logic [11:0] m_blen = 0;
    logic [15:0] m_bcnt = 0;
    logic [27:0] m_len = 0;
    logic [7:0]  m_q[$];

    function automatic int need_of(input logic [1:0] t);
        if (t == 2'd0) return 0;
        if (t == 2'd2) return 16;
        return 4;
    endfunction

    function automatic logic [15:0] m_status();
        logic [15:0] s = 16'd0;
        s[1] = m_tout; s[8] = m_clk; s[13] = m_done;
        return s;
    endfunction

    function automatic logic [15:0] m_entry(input int k);
        logic [15:0] w = 16'd0;
        if (2 * k < m_q.size())     w[7:0]  = m_q[2 * k];
        if (2 * k + 1 < m_q.size()) w[15:8] = m_q[2 * k + 1];
        return w;
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd1: return m_status();
            4'd2: return m_ctrl;
            4'd3: return {9'd0, 1'b1, m_idx};
            4'd4: return m_arg[31:16];
            4'd5: return m_arg[15:0];
            4'd6: return 16'(m_blen);
            4'd7: return m_bcnt;
            4'd8: return (m_ptr < DEPTH) ? m_entry(m_ptr) : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_clk = 0; m_pend = 0; m_tout = 0; m_done = 0;
            m_ctrl = 0; m_idx = 0; m_arg = 0; m_blen = 0; m_bcnt = 0; m_ptr = 0;
            m_q.delete();
        end else begin
            bit wck, wct, go, halt, iss, abt, fin, good;
            wck  = reg_wr && reg_addr == 4'd0;
            wct  = reg_wr && reg_addr == 4'd2;
            go   = wck && reg_wdata[1];
            halt = wck && reg_wdata[0];
            iss  = (wct && !reg_wdata[10] && m_clk) || (go && !halt && m_pend && !m_ctrl[10]);
            abt  = wct || halt;
            if (reg_rd && reg_addr == 4'd8 && m_ptr < DEPTH) m_ptr++;
            if (iss) begin
                m_ph = 1; m_q.delete();
            end else if (abt) begin
                m_ph = 0;
            end else begin
                case (m_ph)
                    1: if (m_ctrl[1:0] == 2'd0) begin
                           m_ph = 4; m_good = 1; m_done = 1; m_ptr = 0;
                       end else begin
                           m_ph = 2; m_wait = 0; m_got = 0;
                       end
                    2: begin
                        fin = 0; good = 0;
                        if (rsp_valid) begin
                            m_got++;
                            if (m_q.size() < 2 * DEPTH) m_q.push_back(rsp_byte);
                        end
                        if (rsp_valid && rsp_last) begin
                            fin = 1; good = m_got >= need_of(m_ctrl[1:0]);
                        end else if (m_wait == RSP_WAIT - 1) fin = 1;
                        else m_wait++;
                        if (fin) begin
                            m_ph = 4; m_good = good;
                            if (good) begin m_done = 1; m_ptr = 0; end
                            else m_tout = 1;
                        end
                    end
                    4: if (m_good && m_ctrl[2]) begin
                           m_ph = 3; m_len = 28'(m_blen * m_bcnt);
                       end else m_ph = 0;
                    default: ;
                endcase
            end
            if (wct) begin m_ctrl = reg_wdata & 16'h3DFF; m_pend = 1; end
            if (go)   m_clk = 1;
            if (halt) m_clk = 0;
            if (iss)  m_pend = 0;
            if ((wct && !reg_wdata[10]) || iss) begin m_tout = 0; m_done = 0; end
            if (reg_wr && reg_addr == 4'd3) m_idx = reg_wdata[5:0];
            if (reg_wr && reg_addr == 4'd4) m_arg[31:16] = reg_wdata;
            if (reg_wr && reg_addr == 4'd5) m_arg[15:0] = reg_wdata;
            if (reg_wr && reg_addr == 4'd6) m_blen = reg_wdata[11:0];
            if (reg_wr && reg_addr == 4'd7) m_bcnt = reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 strobe", 32'(cmd_valid), 32'(m_ph == 1));
            if (m_ph == 1) begin
                check("R2 index", 32'(cmd_index), 32'(m_idx));
                check("R2 argument", cmd_arg, m_arg);
            end
            check("R10 end pulse", 32'(end_cmd), 32'(m_ph == 4));
            check("R11 data phase", 32'(xfer_active), 32'(m_ph == 3));
            if (m_ph == 3) begin
                check("R11 byte budget", 32'(xfer_bytes), 32'(m_len));
                check("R11 direction", 32'(xfer_write), 32'(m_ctrl[3]));
            end
            check("R4 clock", 32'(clk_on), 32'(m_clk));
            check("R3 R5 R6 R7 R13 status", 32'(status), 32'(m_status()));
            case (reg_addr)
                4'd8:    check("R8 R9 response read", 32'(reg_rdata), 32'(m_read(reg_addr)));
                4'd2:    check("R1 control readback", 32'(reg_rdata), 32'(m_read(reg_addr)));
                4'd1:    check("R13 status readback", 32'(reg_rdata), 32'(m_read(reg_addr)));
                default: check("R12 register readback", 32'(reg_rdata), 32'(m_read(reg_addr)));
            endcase
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic look(input logic [3:0] a);
        reg_addr = a; idle(1);
    endtask

    task automatic pop(input int n);
        reg_addr = 4'd8; reg_rd = 1'b1;
        idle(n);
        reg_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        // reset state
        check("R4 reset clock", 32'(clk_on), 32'd0);
        check("R13 reset status", 32'(status), 32'd0);
        check("R2 reset strobe", 32'(cmd_valid), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R1 mask, R12 field widths, R3 stop-transfer stays pending
        wr(4'd2, 16'hFFFF); look(4'd2);
        wr(4'd3, 16'h00FF); look(4'd3);
        wr(4'd4, 16'hA5C3); look(4'd4);
        wr(4'd5, 16'h1E2F); look(4'd5);
        wr(4'd6, 16'hFFFF); look(4'd6);
        wr(4'd7, 16'hFFFF); look(4'd7);
        look(4'd1);
        wr(4'd0, 16'h0002); idle(4);

        // R2 type 1 with 6 bytes, then R9 nine reads and zero
        wr(4'd6, 16'h0004); wr(4'd7, 16'h0003); wr(4'd3, 16'h0011);
        card_plan = 6; card_seed = 8'h21;
        wr(4'd2, 16'h0001); idle(12);
        pop(11); look(4'd1);

        // R11 type 2, 16 bytes, data enabled, write direction; then R4 stop
        card_plan = 16; card_seed = 8'h40;
        wr(4'd2, 16'h000E); idle(24);
        pop(5); idle(2);
        wr(4'd0, 16'h0001); idle(3);

        // R3 control first, clock later; R6 too few bytes for type 2
        wr(4'd2, 16'h0006); idle(3);
        card_plan = 5; card_seed = 8'h77;
        wr(4'd0, 16'h0002); idle(15);
        pop(3);

        // R7 silent card, type 3
        card_plan = 0;
        wr(4'd2, 16'h0003); idle(RSP_WAIT + 8);

        // R5 type 0
        wr(4'd2, 16'h0000); idle(4);

        // R4 stop and start together: stop wins; plain start then issues
        wr(4'd0, 16'h0001);
        card_plan = 4; card_seed = 8'h05;
        wr(4'd2, 16'h0001);
        wr(4'd0, 16'h0003); idle(3);
        wr(4'd0, 16'h0002); idle(10);

        // R13 rewrite during wait aborts and reissues; 8 bytes short for type 2
        card_plan = 0;
        wr(4'd2, 16'h0001); idle(5);
        card_plan = 8; card_seed = 8'h90;
        wr(4'd2, 16'h0002); idle(15);

        // R8 more than 18 bytes
        card_plan = 22; card_seed = 8'h33;
        wr(4'd2, 16'h0001); idle(28);
        pop(10);

        // R11 large budget, read direction, then abort by stop-transfer write
        wr(4'd6, 16'h0200); wr(4'd7, 16'hFFFF);
        card_plan = 4; card_seed = 8'hC0;
        wr(4'd2, 16'h0005); idle(10);
        wr(4'd2, 16'h0400); idle(4);
        look(4'd2);

        finish_run();
    end

endmodule